// File: doc/BRIEF.md
# Set-Less-Than Compare Unit

This block compares two operand words and tells whether the first is below the second, in either two's-complement or unsigned interpretation. A single mode input picks the interpretation. The answer is given in two forms. The first is a full-width result word that holds 1 or 0, ready to be written back as the outcome of a set-on-less-than operation. The second is a set of three flags (equal, below, above) that branch-decision logic can use directly.

The unit contains no relational operator. It forms the difference A + ~B + 1 in one adder of width W+1. Equality comes from a zero difference. The signed "below" answer combines the sign of the difference with the signed-overflow indication. The unsigned "below" answer is the absence of a carry out of the top bit. Both answers therefore come from different flag combinations of the same subtraction.

The unit is purely combinational: outputs follow the inputs within the same cycle, and nothing is held between cycles.

Top module: `slt_compare_unit`

## Requirements
- R1: `eq_flag` is 1 exactly when `op_a` equals `op_b`, in either mode.
- R2: With `signed_mode` = 0, `lt_flag` is 1 exactly when `op_a` is below `op_b` as unsigned numbers (for example, 0x00000000 is below 0xFFFFFFFF).
- R3: With `signed_mode` = 1, `lt_flag` is 1 exactly when `op_a` is below `op_b` as two's-complement numbers. This must hold when the difference overflows: 0x7FFFFFFF is not below 0x80000000, and 0x80000000 is below 0x00000001.
- R4: `gt_flag` is 1 exactly when the operands differ and `lt_flag` is 0, under the same mode.
- R5: `slt_result` equals 1 when `lt_flag` is 1 and 0 otherwise; bits W-1 down to 1 are always 0.
- R6: Exactly one of `eq_flag`, `lt_flag` and `gt_flag` is 1 for any known inputs.
- R7: The outputs depend only on the present inputs. A change of operands or mode is reflected within the same cycle, with no clock and no stored state.
- R8: Flipping only `signed_mode` on the same operands reverses the order when exactly one operand has its top bit set. For example, 0xFFFFFFFF against 0x00000000 is above in unsigned mode and below in signed mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | W (32) | First operand, the minuend |
| op_b | input | W (32) | Second operand, the subtrahend |
| signed_mode | input | 1 | 1 = two's-complement compare, 0 = unsigned compare |
| slt_result | output | W (32) | 1 when op_a is below op_b, else 0 |
| eq_flag | output | 1 | Operands are equal |
| lt_flag | output | 1 | op_a is below op_b in the selected mode |
| gt_flag | output | 1 | op_a is above op_b in the selected mode |

## Verification
The unit holds no state, so a wrong internal value can only be a wrong difference bit, carry or overflow indication. Any of these shows at the ports in the same evaluation that produced it. A wrong overflow term appears only when the operand signs differ and the difference crosses the signed range, so the bench applies extreme values such as 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF in both modes. A wrong carry shows only in unsigned mode, and only where the operands' top bits differ or the operands are close together. Random pairs with forced sign patterns and equal pairs cover the zero-difference path.

// File: rtl/slt_pkg.sv
// Package: shared width default and the flag bundle passed between the
// subtractor, the decoder and the top of the compare unit.
package slt_pkg;

    localparam int unsigned SLT_DW_DEFAULT = 32;

    // Raw indications produced by the subtractor.
    typedef struct packed {
        logic zero;     // difference is all zeros
        logic neg;      // top bit of the difference
        logic ovf;      // signed overflow of the subtraction
        logic carry;    // carry out of the top bit (1 = no borrow)
    } sub_ind_t;

    // Decoded ordering of the two operands.
    typedef struct packed {
        logic eq;
        logic lt;
        logic gt;
    } order_t;

endpackage

// File: rtl/slt_subtractor.sv
// Module: slt_subtractor
// Forms a - b as a + ~b + 1 in one adder of width DW+1 and reports
// zero, sign, signed overflow and carry out. Assumes DW >= 2.
module slt_subtractor
    import slt_pkg::*;
#(
    parameter int unsigned DW = SLT_DW_DEFAULT
) (
    input  logic [DW-1:0] a_in,
    input  logic [DW-1:0] b_in,
    output logic [DW-1:0] diff_out,
    output sub_ind_t      ind_out
);

    localparam int unsigned MSB = DW - 1;

    logic [DW:0] sum_w;

    // Purpose: extended add of a, inverted b and a carry-in of one.
    always_comb begin
        sum_w = {1'b0, a_in} + {1'b0, ~b_in} + {{DW{1'b0}}, 1'b1};
    end

    // Purpose: split the sum into the difference and the indications.
    always_comb begin
        diff_out      = sum_w[DW-1:0];
        ind_out.carry = sum_w[DW];
        ind_out.neg   = sum_w[MSB];
        ind_out.zero  = ~|sum_w[DW-1:0];
        ind_out.ovf   = (a_in[MSB] ^ b_in[MSB]) & (sum_w[MSB] ^ a_in[MSB]);
    end

    // Purpose: guard the subtractor's indications against its operands.
    always_comb begin
        if (!$isunknown({a_in, b_in})) begin
            // R1: equal operands must give a zero difference
            a_r1_equal_gives_zero: assert ((a_in != b_in) || ind_out.zero)
                else $error("equal operands without zero difference");
            // R3: overflow only when the operand signs differ
            a_r3_ovf_needs_mixed_signs: assert (!ind_out.ovf || (a_in[MSB] != b_in[MSB]))
                else $error("overflow with like-signed operands");
            // R2: a zero difference never borrows
            a_r2_zero_has_carry: assert (!ind_out.zero || ind_out.carry)
                else $error("zero difference with borrow");
        end
    end

endmodule

// File: rtl/slt_order_decode.sv
// Module: slt_order_decode
// Turns the subtractor indications into equal / below / above under the
// selected mode. Signed below = neg XOR ovf; unsigned below = no carry.
module slt_order_decode
    import slt_pkg::*;
(
    input  sub_ind_t ind_in,
    input  logic     signed_mode_in,
    output order_t   ord_out
);

    logic lt_signed_w;
    logic lt_unsigned_w;

    // Purpose: the two candidate below answers from the same subtraction.
    always_comb begin
        lt_signed_w   = ind_in.neg ^ ind_in.ovf;
        lt_unsigned_w = ~ind_in.carry;
    end

    // Purpose: choose by mode and derive equal and above.
    always_comb begin
        ord_out.eq = ind_in.zero;
        ord_out.lt = signed_mode_in ? lt_signed_w : lt_unsigned_w;
        ord_out.gt = ~ind_in.zero & ~ord_out.lt;
    end

    // Purpose: guard the decoded ordering.
    always_comb begin
        if (!$isunknown({ind_in, signed_mode_in})) begin
            // R6: one and only one ordering is reported
            a_r6_one_order: assert ($countones({ord_out.eq, ord_out.lt, ord_out.gt}) == 1)
                else $error("ordering not one-hot");
        end
    end

endmodule

// File: rtl/slt_compare_unit.sv
// Module: slt_compare_unit (top)
// Combinational set-less-than compare: subtractor, decoder and result
// word. No clock and no state; outputs follow inputs directly.
module slt_compare_unit
    import slt_pkg::*;
#(
    parameter int unsigned W = SLT_DW_DEFAULT
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic         signed_mode,
    output logic [W-1:0] slt_result,
    output logic         eq_flag,
    output logic         lt_flag,
    output logic         gt_flag
);

    logic [W-1:0] diff_w;
    sub_ind_t     ind_w;
    order_t       ord_w;

    slt_subtractor #(.DW(W)) u_sub (
        .a_in    (op_a),
        .b_in    (op_b),
        .diff_out(diff_w),
        .ind_out (ind_w)
    );

    slt_order_decode u_dec (
        .ind_in        (ind_w),
        .signed_mode_in(signed_mode),
        .ord_out       (ord_w)
    );

    // Purpose: drive the flag ports and the zero-extended result word.
    always_comb begin
        eq_flag    = ord_w.eq;
        lt_flag    = ord_w.lt;
        gt_flag    = ord_w.gt;
        slt_result = {{(W-1){1'b0}}, ord_w.lt};
    end

    // Purpose: guard the port-level relations.
    always_comb begin
        if (!$isunknown({op_a, op_b, signed_mode})) begin
            // R5: upper result bits stay clear
            a_r5_result_upper_zero: assert (slt_result[W-1:1] == '0)
                else $error("result upper bits set");
            // R1: equal flag agrees with operand identity
            a_r1_eq_matches_operands: assert (eq_flag == (op_a == op_b))
                else $error("equal flag disagrees with operands");
            // R4: above excludes equal
            a_r4_gt_not_eq: assert (!(gt_flag && eq_flag))
                else $error("above and equal together");
            // R8: mixed-sign operands order oppositely across modes
            a_r8_mixed_sign_order: assert (
                (op_a[W-1] == op_b[W-1]) ||
                (lt_flag == (signed_mode ? op_a[W-1] : op_b[W-1])))
                else $error("mixed-sign order wrong for mode");
        end
    end

endmodule

// File: tb/tb_slt_compare_unit.sv
module tb_slt_compare_unit;

    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic         signed_mode = 1'b0;
    logic [W-1:0] slt_result;
    logic         eq_flag, lt_flag, gt_flag;

    int n_cmp = 0;
    int n_bad = 0;
    int wd_cnt = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    slt_compare_unit #(.W(W)) dut (
        .op_a(op_a), .op_b(op_b), .signed_mode(signed_mode),
        .slt_result(slt_result), .eq_flag(eq_flag),
        .lt_flag(lt_flag), .gt_flag(gt_flag)
    );

    function automatic bit ref_lt(input logic [W-1:0] a, input logic [W-1:0] b, input bit s);
        if (s) return ($signed(a) < $signed(b));
        return (a < b);
    endfunction

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s a=%h b=%h s=%0d actual=%h expected=%h",
                     tag, op_a, op_b, signed_mode, act, exp);
        end
    endtask

    // Apply one vector at the falling edge, sample 2 ns later (combinational).
    task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b, input bit s);
        bit el;
        @(negedge clk);
        op_a = a; op_b = b; signed_mode = s;
        #2;
        el = ref_lt(a, b, s);
        chk("R1 eq", {31'b0, eq_flag}, {31'b0, (a == b)});
        if (s) chk("R3 signed lt", {31'b0, lt_flag}, {31'b0, el});
        else   chk("R2 unsigned lt", {31'b0, lt_flag}, {31'b0, el});
        chk("R4 gt", {31'b0, gt_flag}, {31'b0, (a != b) && !el});
        chk("R5 result", slt_result, {31'b0, el});
        chk("R6 onehot", {31'b0, (eq_flag + lt_flag + gt_flag == 1)}, 32'd1);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        if (!rst_n) wd_cnt <= 0;
        else wd_cnt <= wd_cnt + 1;
        if (wd_cnt > 100000 && !done) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected<=100000", wd_cnt);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] corners [0:7];
        int seed;
        corners[0] = 32'h0000_0000; corners[1] = 32'h0000_0001;
        corners[2] = 32'h7FFF_FFFF; corners[3] = 32'h8000_0000;
        corners[4] = 32'h8000_0001; corners[5] = 32'hFFFF_FFFF;
        corners[6] = 32'hFFFF_FFFE; corners[7] = 32'h5555_AAAA;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // Reset-time state: zero operands are equal in either mode (R1, R5)
        apply(32'h0, 32'h0, 1'b0);

        // R3 overflow corners, spelled out
        apply(32'h7FFF_FFFF, 32'h8000_0000, 1'b1);
        chk("R3 no-below on overflow", {31'b0, lt_flag}, 32'd0);
        apply(32'h8000_0000, 32'h0000_0001, 1'b1);
        chk("R3 below on overflow", {31'b0, lt_flag}, 32'd1);

        // R8 mode flip on identical operands
        apply(32'hFFFF_FFFF, 32'h0, 1'b0);
        chk("R8 unsigned above", {31'b0, gt_flag}, 32'd1);
        apply(32'hFFFF_FFFF, 32'h0, 1'b1);
        chk("R8 signed below", {31'b0, lt_flag}, 32'd1);

        // R7: operands change without any edge, outputs follow
        op_a = 32'd3; op_b = 32'd9; signed_mode = 1'b0;
        #1 chk("R7 immediate", {31'b0, lt_flag}, 32'd1);
        op_a = 32'd9; op_b = 32'd3;
        #1 chk("R7 immediate", {31'b0, gt_flag}, 32'd1);

        // All corner pairs in both modes (R2, R3)
        for (int i = 0; i < 8; i++)
            for (int j = 0; j < 8; j++)
                for (int m = 0; m < 2; m++)
                    apply(corners[i], corners[j], m[0]);

        // Constrained random: forced sign patterns, near values, equal pairs
        seed = $urandom(32'd20240611);
        for (int k = 0; k < 3000; k++) begin
            logic [W-1:0] ra, rb;
            ra = $urandom; rb = $urandom;
            case (k % 4)
                0: ;
                1: begin ra[W-1] = ~rb[W-1]; end
                2: rb = ra + ($urandom % 5) - 2;
                default: rb = ra;
            endcase
            apply(ra, rb, k[2]);
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule